// File: doc/BRIEF.md
# Genlock Reference-Loss Supervisor

This block supervises a video clock PLL that is meant to follow an external reference. It watches the raw reference pulse train and the loop's phase-lock indication, and it steps through four operating states: locking, locked, free run and holdover. From the state it derives two status flags (no-reference and no-lock), an enable for the loop-filter charge driver and a select that lets the oscillator run open-loop.

Reference presence is judged by edge timing in system clock cycles. A reference is lost when no rising edge arrives within a programmable window. It counts as valid again only after a programmable run of edges, each inside that window. The lock indication is synchronised and must hold a new level for a programmable number of cycles before the controller acts on it. When the reference disappears, a configuration bit selects one of two behaviours. In free run the oscillator runs open-loop. In holdover the filter driver is released to high impedance so the filter keeps its stored control level. When a valid reference comes back, a new lock attempt starts at once. A mode bit turns the whole genlock function off, and the outputs then free run whatever the reference does.

Top module: `genlock_supervisor`

States and transitions: LOCKING goes to LOCKED on qualified lock. LOCKED goes to LOCKING when qualified lock drops while the reference is still valid. LOCKING or LOCKED goes to HOLDOVER (holdover bit 1) or FREERUN (holdover bit 0) on reference loss. FREERUN or HOLDOVER goes to LOCKING when the reference becomes valid. Any state goes to FREERUN while the genlock mode bit is 0.

## Requirements
- R1: A synchronous active-low reset puts the block in LOCKING when `genlock_en` is 1 and in FREERUN when it is 0.
- R2: Outputs per state, written {no_ref, no_lock, lpf_drive_en, vco_open_loop}: LOCKED = 0010, LOCKING = 0110, FREERUN = 1111, HOLDOVER = 1100. No-lock is never 0 while no-ref is 1.
- R3: With `genlock_en` = 1, the reference is lost once no rising edge of `ref_in` has arrived for more than REF_TIMEOUT cycles. A period of REF_TIMEOUT cycles is still valid. On loss, LOCKING or LOCKED moves to HOLDOVER if `holdover_en` = 1 and to FREERUN if it is 0.
- R4: In HOLDOVER the filter driver enable is 0. It drops in the same cycle that no-ref rises.
- R5: The reference becomes valid after REF_GOOD consecutive rising edges, each within the timeout. FREERUN or HOLDOVER then moves straight to LOCKING, never straight to LOCKED. A slower train never qualifies.
- R6: LOCKING moves to LOCKED once `lock_in` has stayed high for LOCK_STABLE cycles after its two-flop synchroniser.
- R7: LOCKED returns to LOCKING when `lock_in` stays low for LOCK_STABLE synchronised cycles while the reference stays valid.
- R8: A `lock_in` pulse shorter than LOCK_STABLE cycles has no effect on the state.
- R9: While `genlock_en` = 0 the block stays in FREERUN whatever `ref_in` and `lock_in` do. The cycle after `genlock_en` rises it leaves FREERUN only if the reference is valid.
- R10: `holdover_en` is read only at the moment of reference loss. Changing it while LOCKED leaves every output unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| genlock_en | input | 1 | 1 = follow reference, 0 = free-running mode |
| holdover_en | input | 1 | Behaviour on reference loss: 1 = holdover, 0 = free run |
| ref_in | input | 1 | Raw reference pulse, asynchronous |
| lock_in | input | 1 | Phase-lock indication from the loop, asynchronous |
| no_ref | output | 1 | Reference absent flag |
| no_lock | output | 1 | Loop not locked flag |
| lpf_drive_en | output | 1 | Loop filter driver enable (0 = high impedance) |
| vco_open_loop | output | 1 | Oscillator open-loop select |

## Verification
The checker watches the output encoding on every cycle. No-lock may not fall while no-ref is high. The driver may only be off together with no-ref and with the loop closed. Its fall must coincide with the rise of no-ref. Every exit from a no-reference state must land in locking, and free-running mode must always show open-loop. What the assertions cannot see is timing against the inputs: how many edges and how long a gap decide reference validity, how long lock must persist, and that a short lock pulse or a late change of the holdover bit leaves everything unchanged. The bench shows these by sweeping reference periods on both sides of the timeout, for both holdover settings.

// File: rtl/genlock_pkg.sv
`timescale 1ns/1ps
package genlock_pkg;
    typedef enum logic [1:0] {
        GL_LOCKING  = 2'd0,
        GL_LOCKED   = 2'd1,
        GL_FREERUN  = 2'd2,
        GL_HOLDOVER = 2'd3
    } gl_state_e;
endpackage

// File: rtl/gl_sync.sv
`timescale 1ns/1ps
module gl_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-2:0], d_async};
        end
    end

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/gl_ref_monitor.sv
`timescale 1ns/1ps
module gl_ref_monitor #(
    parameter int REF_TIMEOUT = 1024,
    parameter int REF_GOOD    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_raw,
    output logic ref_ok
);
    localparam int GAP_W  = $clog2(REF_TIMEOUT + 1);
    localparam int GOOD_W = $clog2(REF_GOOD + 1);
    localparam logic [GAP_W-1:0]  GAP_LAST  = GAP_W'(REF_TIMEOUT - 1);
    localparam logic [GOOD_W-1:0] GOOD_LAST = GOOD_W'(REF_GOOD - 1);

    logic              ref_s;
    logic              ref_d;
    logic              rise;
    logic [GAP_W-1:0]  gap_cnt;
    logic [GOOD_W-1:0] good_cnt;

    gl_sync #(.STAGES(SYNC_STAGES)) u_ref_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_async(ref_raw),
        .q_sync (ref_s)
    );

    assign rise = ref_s & ~ref_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_d    <= 1'b0;
            gap_cnt  <= '0;
            good_cnt <= '0;
            ref_ok   <= 1'b0;
        end else begin
            ref_d <= ref_s;
            if (rise) begin
                gap_cnt <= '0;
                if (!ref_ok) begin
                    if (good_cnt == GOOD_LAST) begin
                        ref_ok   <= 1'b1;
                        good_cnt <= '0;
                    end else begin
                        good_cnt <= good_cnt + 1'b1;
                    end
                end
            end else if (gap_cnt == GAP_LAST) begin
                ref_ok   <= 1'b0;
                good_cnt <= '0;
            end else begin
                gap_cnt <= gap_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/gl_lock_qual.sv
`timescale 1ns/1ps
module gl_lock_qual #(
    parameter int LOCK_STABLE = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lock_raw,
    output logic lock_ok
);
    localparam int CNT_W = $clog2(LOCK_STABLE + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LOCK_STABLE - 1);

    logic             lock_s;
    logic [CNT_W-1:0] diff_cnt;

    gl_sync #(.STAGES(SYNC_STAGES)) u_lock_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_async(lock_raw),
        .q_sync (lock_s)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_ok  <= 1'b0;
            diff_cnt <= '0;
        end else if (lock_s == lock_ok) begin
            diff_cnt <= '0;
        end else if (diff_cnt == CNT_LAST) begin
            lock_ok  <= lock_s;
            diff_cnt <= '0;
        end else begin
            diff_cnt <= diff_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/gl_state_ctrl.sv
`timescale 1ns/1ps
module gl_state_ctrl
    import genlock_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic genlock_en,
    input  logic holdover_en,
    input  logic ref_ok,
    input  logic lock_ok,
    output logic no_ref,
    output logic no_lock,
    output logic lpf_drive_en,
    output logic vco_open_loop
);
    gl_state_e state_q;
    gl_state_e state_d;
    gl_state_e lost_state;

    assign lost_state = holdover_en ? GL_HOLDOVER : GL_FREERUN;

    always_comb begin
        state_d = state_q;
        if (!genlock_en) begin
            state_d = GL_FREERUN;
        end else begin
            unique case (state_q)
                GL_LOCKING: begin
                    if (!ref_ok)      state_d = lost_state;
                    else if (lock_ok) state_d = GL_LOCKED;
                end
                GL_LOCKED: begin
                    if (!ref_ok)       state_d = lost_state;
                    else if (!lock_ok) state_d = GL_LOCKING;
                end
                GL_FREERUN: begin
                    if (ref_ok) state_d = GL_LOCKING;
                end
                GL_HOLDOVER: begin
                    if (ref_ok) state_d = GL_LOCKING;
                end
                default: state_d = GL_FREERUN;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= genlock_en ? GL_LOCKING : GL_FREERUN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        no_ref        = 1'b1;
        no_lock       = 1'b1;
        lpf_drive_en  = 1'b1;
        vco_open_loop = 1'b1;
        unique case (state_q)
            GL_LOCKED: begin
                no_ref        = 1'b0;
                no_lock       = 1'b0;
                vco_open_loop = 1'b0;
            end
            GL_LOCKING: begin
                no_ref        = 1'b0;
                vco_open_loop = 1'b0;
            end
            GL_HOLDOVER: begin
                lpf_drive_en  = 1'b0;
                vco_open_loop = 1'b0;
            end
            GL_FREERUN: begin
                no_ref = 1'b1;
            end
            default: no_ref = 1'b1;
        endcase
    end
endmodule

// File: rtl/genlock_supervisor.sv
`timescale 1ns/1ps
module genlock_supervisor #(
    parameter int REF_TIMEOUT = 1024,
    parameter int REF_GOOD    = 4,
    parameter int LOCK_STABLE = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic genlock_en,
    input  logic holdover_en,
    input  logic ref_in,
    input  logic lock_in,
    output logic no_ref,
    output logic no_lock,
    output logic lpf_drive_en,
    output logic vco_open_loop
);
    logic ref_ok;
    logic lock_ok;

    gl_ref_monitor #(
        .REF_TIMEOUT(REF_TIMEOUT),
        .REF_GOOD   (REF_GOOD),
        .SYNC_STAGES(SYNC_STAGES)
    ) u_ref_mon (
        .clk    (clk),
        .rst_n  (rst_n),
        .ref_raw(ref_in),
        .ref_ok (ref_ok)
    );

    gl_lock_qual #(
        .LOCK_STABLE(LOCK_STABLE),
        .SYNC_STAGES(SYNC_STAGES)
    ) u_lock_q (
        .clk     (clk),
        .rst_n   (rst_n),
        .lock_raw(lock_in),
        .lock_ok (lock_ok)
    );

    gl_state_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .genlock_en   (genlock_en),
        .holdover_en  (holdover_en),
        .ref_ok       (ref_ok),
        .lock_ok      (lock_ok),
        .no_ref       (no_ref),
        .no_lock      (no_lock),
        .lpf_drive_en (lpf_drive_en),
        .vco_open_loop(vco_open_loop)
    );
endmodule

// File: rtl/genlock_supervisor_chk.sv
`timescale 1ns/1ps
module genlock_supervisor_chk (
    input logic clk,
    input logic rst_n,
    input logic genlock_en,
    input logic no_ref,
    input logic no_lock,
    input logic lpf_drive_en,
    input logic vco_open_loop
);
    a_r2_lock_needs_ref: assert property (@(posedge clk) disable iff (!rst_n)
        !no_lock |-> !no_ref);

    a_r2_driver_off_state: assert property (@(posedge clk) disable iff (!rst_n)
        !lpf_drive_en |-> (no_ref && !vco_open_loop));

    a_r4_holdover_with_noref: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lpf_drive_en) |-> $rose(no_ref));

    a_r5_relock_via_locking: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(no_ref) |-> no_lock);

    a_r6_locked_from_locking: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(no_lock) |-> !$past(no_ref));

    a_r9_mode_off_freeruns: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(genlock_en) == 1'b0) |-> (vco_open_loop && no_ref && no_lock));
endmodule

bind genlock_supervisor genlock_supervisor_chk u_chk (.*);

// File: tb/test_genlock_supervisor.sv
`timescale 1ns/1ps
module test_genlock_supervisor;
    localparam int CLK_PERIOD = 10;
    localparam int T_OUT      = 16;
    localparam int N_GOOD     = 3;
    localparam int N_STABLE   = 4;

    localparam logic [3:0] EXP_LOCKED   = 4'b0010;
    localparam logic [3:0] EXP_LOCKING  = 4'b0110;
    localparam logic [3:0] EXP_FREERUN  = 4'b1111;
    localparam logic [3:0] EXP_HOLDOVER = 4'b1100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic genlock_en = 1'b1;
    logic holdover_en = 1'b0;
    logic ref_in = 1'b0;
    logic lock_in = 1'b0;
    logic no_ref, no_lock, lpf_drive_en, vco_open_loop;
    logic [3:0] obs;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    bit ref_run = 1'b0;
    int ref_per = 8;
    int ref_phase = 0;

    genlock_supervisor #(
        .REF_TIMEOUT(T_OUT),
        .REF_GOOD   (N_GOOD),
        .LOCK_STABLE(N_STABLE),
        .SYNC_STAGES(2)
    ) i_genlock_supervisor (
        .clk          (clk),
        .rst_n        (rst_n),
        .genlock_en   (genlock_en),
        .holdover_en  (holdover_en),
        .ref_in       (ref_in),
        .lock_in      (lock_in),
        .no_ref       (no_ref),
        .no_lock      (no_lock),
        .lpf_drive_en (lpf_drive_en),
        .vco_open_loop(vco_open_loop)
    );

    assign obs = {no_ref, no_lock, lpf_drive_en, vco_open_loop};

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        if (!ref_run) begin
            ref_in    = 1'b0;
            ref_phase = 0;
        end else begin
            ref_in    = (ref_phase == 0);
            ref_phase = (ref_phase + 1 >= ref_per) ? 0 : ref_phase + 1;
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input string tag, input logic [3:0] exp);
        checks++;
        if (obs !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b (t=%0t)", tag, obs, exp, $time);
        end
    endtask

    function automatic logic [3:0] lost_exp(input bit h);
        return h ? EXP_HOLDOVER : EXP_FREERUN;
    endfunction

    task automatic apply_reset(input bit gl);
        rst_n      = 1'b0;
        genlock_en = gl;
        ref_run    = 1'b0;
        lock_in    = 1'b0;
        step(2);
        check("R1 reset state", gl ? EXP_LOCKING : EXP_FREERUN);
    endtask

    initial begin
        int per_tab[5] = '{4, 9, 16, 17, 24};
        for (int h = 0; h < 2; h++) begin
            for (int pi = 0; pi < 5; pi++) begin
                int per;
                per = per_tab[pi];
                holdover_en = h[0];
                apply_reset(1'b0);
                apply_reset(1'b1);
                rst_n = 1'b1;
                step(3);
                check("R3 no reference after reset", lost_exp(h[0]));
                ref_per = per;
                ref_run = 1'b1;
                if (per > T_OUT) begin
                    lock_in = 1'b1;
                    step(8 * per);
                    check("R5 slow reference never qualifies", lost_exp(h[0]));
                    ref_run = 1'b0;
                end else begin
                    step(2 * per);
                    check("R5 too few edges", lost_exp(h[0]));
                    step(8);
                    check("R5 valid reference gives locking", EXP_LOCKING);
                    lock_in = 1'b1;
                    step(2);
                    lock_in = 1'b0;
                    step(8);
                    check("R8 short lock pulse ignored", EXP_LOCKING);
                    lock_in = 1'b1;
                    step(3);
                    check("R6 lock not accepted early", EXP_LOCKING);
                    step(6);
                    check("R6 qualified lock gives locked", EXP_LOCKED);
                    holdover_en = ~h[0];
                    step(4);
                    check("R10 holdover bit change while locked", EXP_LOCKED);
                    holdover_en = h[0];
                    lock_in = 1'b0;
                    step(10);
                    check("R7 lock loss returns to locking", EXP_LOCKING);
                    lock_in = 1'b1;
                    step(10);
                    check("R6 relock", EXP_LOCKED);
                    ref_run = 1'b0;
                    step(T_OUT + per + 6);
                    check(h ? "R4 holdover on reference loss" : "R3 free run on reference loss",
                          lost_exp(h[0]));
                    ref_run = 1'b1;
                    step(3 * per + 10);
                    check("R5 reference return relocks", EXP_LOCKED);
                    genlock_en = 1'b0;
                    step(3);
                    check("R9 mode off with reference", EXP_FREERUN);
                    lock_in = 1'b0;
                    step(40);
                    check("R9 mode off lock dropped", EXP_FREERUN);
                    ref_run = 1'b0;
                    lock_in = 1'b1;
                    step(40);
                    check("R9 mode off no reference", EXP_FREERUN);
                    ref_run = 1'b1;
                    step(3 * per + 10);
                    check("R9 mode off reference back", EXP_FREERUN);
                    genlock_en = 1'b1;
                    step(5);
                    check("R9 mode on relocks", EXP_LOCKED);
                    ref_run = 1'b0;
                end
            end
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule